// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which operating mode a small microcontroller is in and drives the controls that follow from that mode. The CPU asks for a low-power mode with a one-cycle request and a two-bit target code. The sequencer then halts the CPU, gates the main oscillator and the peripheral clock, sends reset pulses to selected peripheral groups and puts the I/O pads into high impedance, as the target mode requires.

The block stays in the low-power mode until an interrupt qualifies as a wake-up. A request wakes the chip only if its source is enabled and the CPU global interrupt mask is clear. The block then returns to full-speed operation, or to the slow-clock running mode when the run-mode select input is set, and it marks the start of exception handling with a one-cycle pulse. An asynchronous active-low reset puts the block back in full-speed operation from any mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, the block is in full-speed mode at once, without waiting for a clock edge: `mode_o`=0, `cpu_halt`=0, `osc_en`=1, `io_hiz`=0, `wake_exc`=0 and `periph_rst`=0.
- R2: A `sleep_req` taken in full-speed or slow-clock running mode moves the block at that clock edge to the mode named by `mode_sel`: code 0 selects sleep, code 1 selects subsleep and code 2 selects standby.
- R3: A `sleep_req` with `mode_sel`=3 has no effect, and the mode does not change.
- R4: `cpu_halt` is 1 in sleep, subsleep and standby, and 0 in both running modes.
- R5: `osc_en` is 1 only in full-speed mode and in sleep.
- R6: `pclk_en` is 0 in subsleep and standby and 1 in every other mode. `pclk_div` equals `div_sel` in sleep and is 0 in every other mode.
- R7: `io_hiz` is 1 only in standby.
- R8: In any halted mode, if some bit has both `irq_req` and `irq_en` set and `irq_mask` is 0, the block leaves the halted mode at the next edge. `wake_exc` is then 1 for exactly the cycle after that edge.
- R9: A halted mode is kept while `irq_mask` is 1, and also while no requesting source is enabled.
- R10: A wake-up goes to slow-clock running mode when `run_sub` is 1, and to full-speed mode when it is 0.
- R11: At the edge that enters subsleep or standby, the bits of `periph_rst` that are set in `RST_MASK` go high for exactly one cycle. The default mask is bits 0 to 3. Entering sleep never pulses `periph_rst`.
- R12: `mode_o` reports the mode with these codes: full-speed 0, slow-clock running 1, sleep 2, subsleep 3, standby 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| sleep_req | input | 1 | One-cycle request from the CPU to enter a low-power mode |
| mode_sel | input | 2 | Target code for the request: 0 sleep, 1 subsleep, 2 standby, 3 reserved |
| run_sub | input | 1 | When 1, a wake-up goes to slow-clock running mode |
| div_sel | input | DIV_W | Peripheral clock divider select that is used in sleep |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Enable for each interrupt source |
| irq_mask | input | 1 | CPU global interrupt mask; 1 blocks wake-up |
| mode_o | output | 3 | Current mode code |
| cpu_halt | output | 1 | Stops CPU instruction execution |
| osc_en | output | 1 | Enables the system clock oscillator |
| pclk_en | output | 1 | Enables the peripheral clock |
| pclk_div | output | DIV_W | Divider select sent on to the peripheral clock |
| periph_rst | output | NUM_PERIPH | One-cycle reset pulse for each peripheral group |
| io_hiz | output | 1 | Puts the port outputs into high impedance |
| wake_exc | output | 1 | Marks the start of wake-up exception handling |

## Verification
The assertions assume that `sleep_req` arrives only while the CPU is running, and that the interrupt inputs hold their values across each clock edge. The masked-wake property also relies on the wake-up path being the only exit from a halted mode other than reset. The bench changes every input at the falling edge and holds it for a full cycle. It raises `sleep_req` for single cycles only in a running mode. It applies `rst_n` only after the scoreboard queue has drained, so the asynchronous reset never overlaps an expected item that has not yet been checked.

// File: rtl/pms_pkg.sv
package pms_pkg;
   typedef enum logic [2:0] {
      PM_ACTIVE = 3'd0,
      PM_SUBACT = 3'd1,
      PM_SLEEP  = 3'd2,
      PM_SUBSLP = 3'd3,
      PM_STBY   = 3'd4
   } pm_mode_e;

   typedef enum logic [1:0] {
      TGT_SLEEP  = 2'd0,
      TGT_SUBSLP = 2'd1,
      TGT_STBY   = 2'd2,
      TGT_RSVD   = 2'd3
   } pm_target_e;
endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
   parameter int NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               irq_mask,
   output logic               wake
);
   logic [NUM_IRQ-1:0] live;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_src
         assign live[gi] = irq_req[gi] & irq_en[gi];
      end
   endgenerate

   assign wake = (|live) & ~irq_mask;
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic [1:0] mode_sel,
   input  logic       run_sub,
   input  logic       wake,
   output pm_mode_e   mode_q,
   output logic       deep_pulse,
   output logic       wake_pulse
);
   pm_mode_e nxt;
   logic     take_deep;
   logic     take_wake;

   always_comb begin
      nxt       = mode_q;
      take_deep = 1'b0;
      take_wake = 1'b0;
      case (mode_q)
         PM_ACTIVE, PM_SUBACT: begin
            if (sleep_req) begin
               case (pm_target_e'(mode_sel))
                  TGT_SLEEP:  nxt = PM_SLEEP;
                  TGT_SUBSLP: begin
                     nxt       = PM_SUBSLP;
                     take_deep = 1'b1;
                  end
                  TGT_STBY: begin
                     nxt       = PM_STBY;
                     take_deep = 1'b1;
                  end
                  default: nxt = mode_q;
               endcase
            end
         end
         PM_SLEEP, PM_SUBSLP, PM_STBY: begin
            if (wake) begin
               nxt       = run_sub ? PM_SUBACT : PM_ACTIVE;
               take_wake = 1'b1;
            end
         end
         default: nxt = PM_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= PM_ACTIVE;
         deep_pulse <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         mode_q     <= nxt;
         deep_pulse <= take_deep;
         wake_pulse <= take_wake;
      end
   end
endmodule

// File: rtl/pms_strobe.sv
module pms_strobe #(
   parameter int                    NUM_PERIPH = 8,
   parameter logic [NUM_PERIPH-1:0] RST_MASK   = '1
) (
   input  logic                  fire,
   output logic [NUM_PERIPH-1:0] periph_rst
);
   genvar gp;
   generate
      for (gp = 0; gp < NUM_PERIPH; gp++) begin : g_grp
         if (RST_MASK[gp]) begin : g_reset
            assign periph_rst[gp] = fire;
         end else begin : g_keep
            assign periph_rst[gp] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int                    NUM_IRQ    = 8,
   parameter int                    DIV_W      = 3,
   parameter int                    NUM_PERIPH = 8,
   parameter logic [NUM_PERIPH-1:0] RST_MASK   = 8'h0F
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sleep_req,
   input  logic [1:0]            mode_sel,
   input  logic                  run_sub,
   input  logic [DIV_W-1:0]      div_sel,
   input  logic [NUM_IRQ-1:0]    irq_req,
   input  logic [NUM_IRQ-1:0]    irq_en,
   input  logic                  irq_mask,
   output logic [2:0]            mode_o,
   output logic                  cpu_halt,
   output logic                  osc_en,
   output logic                  pclk_en,
   output logic [DIV_W-1:0]      pclk_div,
   output logic [NUM_PERIPH-1:0] periph_rst,
   output logic                  io_hiz,
   output logic                  wake_exc
);
   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("pwr_mode_seq: NUM_IRQ must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("pwr_mode_seq: DIV_W must be at least 1");
      end
      if (NUM_PERIPH < 1) begin : g_bad_per
         $error("pwr_mode_seq: NUM_PERIPH must be at least 1");
      end
   endgenerate

   logic     wake;
   logic     deep_pulse;
   pm_mode_e mode_q;

   pms_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_wake (
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_mask (irq_mask),
      .wake     (wake)
   );

   pms_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .mode_sel   (mode_sel),
      .run_sub    (run_sub),
      .wake       (wake),
      .mode_q     (mode_q),
      .deep_pulse (deep_pulse),
      .wake_pulse (wake_exc)
   );

   pms_strobe #(.NUM_PERIPH(NUM_PERIPH), .RST_MASK(RST_MASK)) u_strobe (
      .fire       (deep_pulse),
      .periph_rst (periph_rst)
   );

   assign mode_o   = mode_q;
   assign cpu_halt = (mode_q == PM_SLEEP) || (mode_q == PM_SUBSLP) || (mode_q == PM_STBY);
   assign osc_en   = (mode_q == PM_ACTIVE) || (mode_q == PM_SLEEP);
   assign pclk_en  = !((mode_q == PM_SUBSLP) || (mode_q == PM_STBY));
   assign pclk_div = (mode_q == PM_SLEEP) ? div_sel : '0;
   assign io_hiz   = (mode_q == PM_STBY);
endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
   parameter int NUM_IRQ    = 8,
   parameter int NUM_PERIPH = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sleep_req,
   input logic [1:0]            mode_sel,
   input logic                  irq_mask,
   input logic [2:0]            mode_o,
   input logic                  cpu_halt,
   input logic                  osc_en,
   input logic [NUM_PERIPH-1:0] periph_rst,
   input logic                  io_hiz,
   input logic                  wake_exc
);
   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_rst) |=> (periph_rst == '0)); // R11
   AST_RST_ON_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_rst) |-> ((mode_o == 3'd3) || (mode_o == 3'd4)) && ($past(mode_o) <= 3'd1)); // R11
   AST_WAKE_LEAVES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      wake_exc |-> (!cpu_halt && $past(cpu_halt))); // R8
   AST_MASK_HOLDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && irq_mask) |=> cpu_halt); // R9
   AST_RSVD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_halt && sleep_req && mode_sel == 2'd3) |=> $stable(mode_o)); // R3
   AST_HIZ_ONLY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      io_hiz |-> (cpu_halt && !osc_en && mode_o == 3'd4)); // R7
   AST_OSC_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en |-> (mode_o == 3'd0 || mode_o == 3'd2)); // R5
endmodule

bind pwr_mode_seq pms_chk #(.NUM_IRQ(NUM_IRQ), .NUM_PERIPH(NUM_PERIPH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_req  (sleep_req),
   .mode_sel   (mode_sel),
   .irq_mask   (irq_mask),
   .mode_o     (mode_o),
   .cpu_halt   (cpu_halt),
   .osc_en     (osc_en),
   .periph_rst (periph_rst),
   .io_hiz     (io_hiz),
   .wake_exc   (wake_exc)
);

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;
   localparam int NI = 8;
   localparam int DW = 3;
   localparam int NP = 8;

   typedef struct packed {
      logic [2:0]    mode;
      logic          halt;
      logic          osc;
      logic          pen;
      logic [DW-1:0] div;
      logic [NP-1:0] prst;
      logic          hiz;
      logic          wake;
   } obs_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req = 1'b0;
   logic [1:0]    mode_sel = 2'd0;
   logic          run_sub = 1'b0;
   logic [DW-1:0] div_sel = 3'd5;
   logic [NI-1:0] irq_req = '0;
   logic [NI-1:0] irq_en = '0;
   logic          irq_mask = 1'b0;
   logic [2:0]    mode_o;
   logic          cpu_halt, osc_en, pclk_en, io_hiz, wake_exc;
   logic [DW-1:0] pclk_div;
   logic [NP-1:0] periph_rst;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   obs_t  exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   pwr_mode_seq u_pwr_mode_seq (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
      .run_sub(run_sub), .div_sel(div_sel), .irq_req(irq_req), .irq_en(irq_en),
      .irq_mask(irq_mask), .mode_o(mode_o), .cpu_halt(cpu_halt), .osc_en(osc_en),
      .pclk_en(pclk_en), .pclk_div(pclk_div), .periph_rst(periph_rst),
      .io_hiz(io_hiz), .wake_exc(wake_exc)
   );

   // expected static outputs for a mode code (R4 R5 R6 R7 R12)
   function automatic obs_t model(input logic [2:0] m, input logic [NP-1:0] pr, input logic wk);
      obs_t o;
      o.mode = m;
      o.halt = (m >= 3'd2);
      o.osc  = (m == 3'd0) || (m == 3'd2);
      o.pen  = (m <= 3'd2);
      o.div  = (m == 3'd2) ? div_sel : '0;
      o.prst = pr;
      o.hiz  = (m == 3'd4);
      o.wake = wk;
      return o;
   endfunction

   function automatic obs_t sample();
      obs_t o;
      o = {mode_o, cpu_halt, osc_en, pclk_en, pclk_div, periph_rst, io_hiz, wake_exc};
      return o;
   endfunction

   task automatic check(input obs_t act, input obs_t exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected result pushed for the monitor
   task automatic drive(input logic sr, input logic [1:0] ms, input logic sub,
                        input logic [NI-1:0] rq, input logic [NI-1:0] en, input logic mk,
                        input logic [2:0] m, input logic [NP-1:0] pr, input logic wk,
                        input string tag);
      @(negedge clk);
      sleep_req = sr; mode_sel = ms; run_sub = sub;
      irq_req = rq; irq_en = en; irq_mask = mk;
      exp_q.push_back(model(m, pr, wk));
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         obs_t e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(sample(), e, t);
      end
   end

   initial begin
      #(4 * 5000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #5;
      check(sample(), model(3'd0, '0, 1'b0), "R1 reset state");
      @(negedge clk);
      rst_n = 1'b1;
      drive(0, 2'd0, 0, '0,    '0,    0, 3'd0, 8'h00, 0, "R12 active idle");
      drive(1, 2'd0, 0, '0,    '0,    0, 3'd2, 8'h00, 0, "R2 R6 enter sleep no strobe R11");
      drive(0, 2'd0, 0, 8'h04, 8'h04, 1, 3'd2, 8'h00, 0, "R9 masked stays sleep");
      drive(0, 2'd0, 0, 8'h04, 8'h08, 0, 3'd2, 8'h00, 0, "R9 disabled source stays sleep");
      drive(0, 2'd0, 0, 8'h04, 8'h0C, 0, 3'd0, 8'h00, 1, "R8 R10 wake to active");
      drive(0, 2'd0, 0, '0,    '0,    0, 3'd0, 8'h00, 0, "R8 wake pulse ends");
      drive(1, 2'd3, 0, '0,    '0,    0, 3'd0, 8'h00, 0, "R3 reserved code ignored");
      drive(1, 2'd1, 0, '0,    '0,    0, 3'd3, 8'h0F, 0, "R2 R11 enter subsleep strobe");
      drive(0, 2'd0, 0, '0,    '0,    0, 3'd3, 8'h00, 0, "R11 strobe one cycle R4 R5");
      drive(0, 2'd0, 1, 8'h80, 8'h80, 0, 3'd1, 8'h00, 1, "R10 wake to slow-clock run");
      drive(1, 2'd3, 0, '0,    '0,    0, 3'd1, 8'h00, 0, "R3 reserved code in slow run");
      drive(1, 2'd2, 0, '0,    '0,    0, 3'd4, 8'h0F, 0, "R2 R7 R11 enter standby");
      drive(0, 2'd0, 0, 8'h01, 8'h01, 1, 3'd4, 8'h00, 0, "R9 R7 standby held masked");
      drive(0, 2'd0, 0, 8'h01, 8'h01, 0, 3'd0, 8'h00, 1, "R8 wake from standby");
      drive(1, 2'd2, 0, '0,    '0,    0, 3'd4, 8'h0F, 0, "R2 standby from active");
      drive(0, 2'd0, 0, '0,    '0,    0, 3'd4, 8'h00, 0, "R11 standby strobe ends");
      repeat (2) @(negedge clk);
      #1;
      rst_n = 1'b0;
      #0.5;
      check(sample(), model(3'd0, '0, 1'b0), "R1 async reset from standby");
      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule